// File: doc/BRIEF.md
# I2C Bus Clock Divisor Search Unit

This unit works out how to divide a reference clock down to a two-wire serial bus rate. The divide is done in two stages: a coarse prescaler that divides by either 16 or 512, and a fine divider that divides by 1 to 17. The unit is given the reference rate and three bus rates in kHz: the requested rate, a floor and a ceiling. It reports the control-register fields for the chosen divider setting, the bus rate that setting actually produces, and whether a usable setting was found.

A search begins with a one-cycle start pulse. If the requested rate is nonzero it is tried first. If it is zero, or if its result misses, the unit scans candidate rates downward one kHz at a time. The scan starts at the ceiling, or at the requested rate when the ceiling is zero. The first candidate whose achieved rate falls within 2 kHz of it is reported. Every candidate needs two divisions, and both run on one shared bit-serial restoring divider. The search ends with a one-cycle done pulse. The shape of the SCL waveform is the business of other logic.

Top module: `i2c_div_search`

## Requirements
- R1: For a candidate rate t, let the ratio be floor(reference / t). The coarse select output is 1 (divide by 512) when the ratio is greater than 256. Otherwise it is 0 (divide by 16).
- R2: The fine divider is the ratio divided by the coarse divisor and rounded up, then clamped to the range 1 to 17. The fine field output carries the fine divider minus one, so its values run from 0 to 16.
- R3: The reported rate is floor(reference / (fine divider × coarse divisor)).
- R4: A candidate is accepted only when its achieved rate differs from the candidate by at most 2 kHz in either direction.
- R5: A nonzero requested rate is evaluated before any other candidate. If it is accepted, its settings are the result.
- R6: After the first try (or in its place, when the requested rate is zero), the scan evaluates candidates from the ceiling, or from the requested rate when the ceiling is zero. Each step lowers the candidate by 1 kHz. A candidate is evaluated only while it is strictly above the floor, and the first accepted candidate is the result.
- R7: When no candidate is accepted, the no-fit flag is set and the found flag is cleared. The fine field, the coarse select and the rate are all zero.
- R8: Done is a one-cycle pulse, and exactly one of found and no-fit is set at that pulse. A start pulse that arrives during a search is ignored, together with the inputs that come with it.
- R9: Done rises 2·CLK_W+5 cycles after the start edge for each evaluated candidate. One more cycle is added when the downward scan is entered.
- R10: After reset, done, found, no-fit, the fine field, the coarse select and the rate are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a search |
| ref_khz | input | CLK_W | Reference clock rate in kHz |
| bus_khz | input | RATE_W | Requested bus rate in kHz, 0 = none |
| min_khz | input | RATE_W | Scan floor in kHz (exclusive) |
| max_khz | input | RATE_W | Scan ceiling in kHz, 0 = use requested |
| done | output | 1 | One-cycle end-of-search pulse |
| fit_ok | output | 1 | A setting was found |
| no_fit | output | 1 | No candidate was accepted |
| fine_field | output | 5 | Fine divider minus one |
| sel_coarse | output | 1 | 1 = divide by 512, 0 = divide by 16 |
| rate_khz | output | CLK_W | Achieved bus rate in kHz |

## Verification
Every result appears together with the done pulse. The time to that pulse is set entirely by the number of candidates the search evaluates. Each candidate costs 2·CLK_W+5 cycles: one launch cycle and CLK_W+1 divider cycles per division, plus a cycle to compare. Entering the scan adds one cycle. The bench's arithmetic model counts the candidates the search should visit and predicts the exact posedge at which done must appear. The bench then counts posedges from the start edge, samples at each following negedge, and checks that done appears at exactly that edge and that the outputs match the model there. On the negedge after that, it checks that done has fallen again.

// File: rtl/i2c_div_pkg.sv
package i2c_div_pkg;

    // Width of the fine-divider-minus-one field.
    localparam int FINE_W      = 5;
    // Coarse prescaler divisors expressed as shift amounts (16 and 512).
    localparam int LO_SHIFT    = 4;
    localparam int HI_SHIFT    = 9;
    // Ratio above which the large prescaler is chosen.
    localparam int RATIO_SPLIT = 256;
    // Fine divider limits.
    localparam int FINE_FLOOR  = 1;
    localparam int FINE_CAP    = 17;
    // Acceptance window in kHz (either direction).
    localparam int TOL_KHZ     = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_RATIO,
        S_WAIT_R,
        S_ACH,
        S_WAIT_A,
        S_JUDGE
    } srch_state_e;

    typedef struct packed {
        logic              coarse;
        logic [FINE_W-1:0] fine;
    } presc_t;

    function automatic logic [FINE_W-1:0] clamp_fine(input logic [31:0] raw);
        if (raw < 32'(FINE_FLOOR))
            return FINE_W'(FINE_FLOOR);
        else if (raw > 32'(FINE_CAP))
            return FINE_W'(FINE_CAP);
        else
            return raw[FINE_W-1:0];
    endfunction

endpackage

// File: rtl/i2c_div_serial.sv
module i2c_div_serial #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CNT_W = $clog2(W);
    localparam int DW    = 2 * W;

    logic [W-1:0]     rem_q;
    logic [W-1:0]     num_q;
    logic [W-1:0]     den_q;
    logic [CNT_W-1:0] step_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;
    logic             fits;

    // Trial subtraction for one restoring step.
    always_comb begin
        shifted = {rem_q, quot[W-1]};
        fits    = shifted >= {1'b0, den_q};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            quot   <= '0;
            rem_q  <= '0;
            num_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                quot   <= num;
                rem_q  <= '0;
                num_q  <= num;
                den_q  <= den;
                step_q <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                rem_q  <= fits ? trial[W-1:0] : shifted[W-1:0];
                quot   <= {quot[W-2:0], fits};
                step_q <= step_q + 1'b1;
                if (step_q == CNT_W'(W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Quotient and remainder reconstruct the dividend that was latched.
    logic [DW-1:0] recon;
    always_comb recon = DW'(quot) * DW'(den_q) + DW'(rem_q);

    assert_div_exact_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (recon == DW'(num_q) && rem_q < den_q));

    // The controller never launches a division onto a busy divider (R8).
    assert_go_idle_R8: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy);

endmodule

// File: rtl/i2c_div_presc.sv
module i2c_div_presc
    import i2c_div_pkg::*;
#(
    parameter int CLK_W = 20
) (
    input  logic [CLK_W-1:0] ratio,
    output presc_t           pset,
    output logic [CLK_W-1:0] prod
);
    localparam int RW = CLK_W + 1;

    logic [RW-1:0] ext;
    logic [RW-1:0] lo_sum;
    logic [RW-1:0] hi_sum;
    logic [RW-1:0] raw;

    // Ceiling division by the prescaler via add-then-shift.
    always_comb begin
        ext         = {1'b0, ratio};
        lo_sum      = ext + RW'((1 << LO_SHIFT) - 1);
        hi_sum      = ext + RW'((1 << HI_SHIFT) - 1);
        pset.coarse = ratio > CLK_W'(RATIO_SPLIT);
        raw         = pset.coarse ? (hi_sum >> HI_SHIFT) : (lo_sum >> LO_SHIFT);
        pset.fine   = clamp_fine(32'(raw));
        prod        = CLK_W'(pset.fine) << (pset.coarse ? HI_SHIFT : LO_SHIFT);
    end

endmodule

// File: rtl/i2c_div_ctl.sv
module i2c_div_ctl
    import i2c_div_pkg::*;
#(
    parameter int CLK_W  = 20,
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CLK_W-1:0]  ref_khz,
    input  logic [RATE_W-1:0] bus_khz,
    input  logic [RATE_W-1:0] min_khz,
    input  logic [RATE_W-1:0] max_khz,
    output logic              div_go,
    output logic [CLK_W-1:0]  div_num,
    output logic [CLK_W-1:0]  div_den,
    input  logic              div_done,
    input  logic [CLK_W-1:0]  div_quot,
    input  presc_t            pset,
    input  logic [CLK_W-1:0]  prod,
    output logic              done,
    output logic              fit_ok,
    output logic              no_fit,
    output logic [FINE_W-1:0] fine_field,
    output logic              sel_coarse,
    output logic [CLK_W-1:0]  rate_khz
);
    localparam int XW = CLK_W + 1;

    srch_state_e       st;
    logic [CLK_W-1:0]  ref_r;
    logic [RATE_W-1:0] bus_r;
    logic [RATE_W-1:0] min_r;
    logic [RATE_W-1:0] max_r;
    logic [RATE_W-1:0] cand_r;
    logic              first_r;
    presc_t            pset_r;
    logic [CLK_W-1:0]  prod_r;
    logic [CLK_W-1:0]  ach_r;

    logic [RATE_W-1:0] scan_first;
    logic [RATE_W-1:0] cand_dec;
    logic [XW-1:0]     ach_x;
    logic [XW-1:0]     cand_x;
    logic              accept;

    always_comb begin
        div_go     = (st == S_RATIO) || (st == S_ACH);
        div_num    = ref_r;
        div_den    = (st == S_RATIO) ? CLK_W'(cand_r) : prod_r;
        scan_first = (max_r != '0) ? max_r : bus_r;
        cand_dec   = cand_r - 1'b1;
        ach_x      = {1'b0, ach_r};
        cand_x     = XW'(cand_r);
        accept     = (ach_x + XW'(TOL_KHZ) >= cand_x) &&
                     (cand_x + XW'(TOL_KHZ) >= ach_x);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            ref_r      <= '0;
            bus_r      <= '0;
            min_r      <= '0;
            max_r      <= '0;
            cand_r     <= '0;
            first_r    <= 1'b0;
            pset_r     <= '0;
            prod_r     <= '0;
            ach_r      <= '0;
            done       <= 1'b0;
            fit_ok     <= 1'b0;
            no_fit     <= 1'b0;
            fine_field <= '0;
            sel_coarse <= 1'b0;
            rate_khz   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        ref_r  <= ref_khz;
                        bus_r  <= bus_khz;
                        min_r  <= min_khz;
                        max_r  <= max_khz;
                        fit_ok <= 1'b0;
                        no_fit <= 1'b0;
                        if (bus_khz != '0) begin
                            cand_r  <= bus_khz;
                            first_r <= 1'b1;
                            st      <= S_RATIO;
                        end else begin
                            first_r <= 1'b0;
                            st      <= S_SCAN;
                        end
                    end
                end
                S_SCAN: begin
                    first_r <= 1'b0;
                    if (scan_first > min_r) begin
                        cand_r <= scan_first;
                        st     <= S_RATIO;
                    end else begin
                        done       <= 1'b1;
                        no_fit     <= 1'b1;
                        fit_ok     <= 1'b0;
                        fine_field <= '0;
                        sel_coarse <= 1'b0;
                        rate_khz   <= '0;
                        st         <= S_IDLE;
                    end
                end
                S_RATIO: st <= S_WAIT_R;
                S_WAIT_R: begin
                    if (div_done) begin
                        pset_r <= pset;
                        prod_r <= prod;
                        st     <= S_ACH;
                    end
                end
                S_ACH: st <= S_WAIT_A;
                S_WAIT_A: begin
                    if (div_done) begin
                        ach_r <= div_quot;
                        st    <= S_JUDGE;
                    end
                end
                S_JUDGE: begin
                    if (accept) begin
                        done       <= 1'b1;
                        fit_ok     <= 1'b1;
                        no_fit     <= 1'b0;
                        fine_field <= pset_r.fine - 1'b1;
                        sel_coarse <= pset_r.coarse;
                        rate_khz   <= ach_r;
                        st         <= S_IDLE;
                    end else if (first_r) begin
                        st <= S_SCAN;
                    end else if (cand_dec > min_r) begin
                        cand_r <= cand_dec;
                        st     <= S_RATIO;
                    end else begin
                        done       <= 1'b1;
                        no_fit     <= 1'b1;
                        fit_ok     <= 1'b0;
                        fine_field <= '0;
                        sel_coarse <= 1'b0;
                        rate_khz   <= '0;
                        st         <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    logic [XW-1:0] rate_x;
    always_comb rate_x = {1'b0, rate_khz};

    assert_one_flag_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (fit_ok ^ no_fit));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        (done && fit_ok) |-> ((rate_x + XW'(TOL_KHZ) >= cand_x) &&
                              (cand_x + XW'(TOL_KHZ) >= rate_x)));

    assert_field_range_R2: assert property (@(posedge clk) disable iff (rst)
        (done && fit_ok) |-> (fine_field <= FINE_W'(FINE_CAP - 1)));

    assert_nofit_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (done && no_fit) |-> (fine_field == '0 && !sel_coarse && rate_khz == '0));

    assert_scan_above_min_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_RATIO && !first_r) |-> (cand_r > min_r));

endmodule

// File: rtl/i2c_div_search.sv
module i2c_div_search
    import i2c_div_pkg::*;
#(
    parameter int CLK_W  = 20,
    parameter int RATE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CLK_W-1:0]  ref_khz,
    input  logic [RATE_W-1:0] bus_khz,
    input  logic [RATE_W-1:0] min_khz,
    input  logic [RATE_W-1:0] max_khz,
    output logic              done,
    output logic              fit_ok,
    output logic              no_fit,
    output logic [FINE_W-1:0] fine_field,
    output logic              sel_coarse,
    output logic [CLK_W-1:0]  rate_khz
);
    logic             div_go;
    logic [CLK_W-1:0] div_num;
    logic [CLK_W-1:0] div_den;
    logic             div_busy;
    logic             div_done;
    logic [CLK_W-1:0] div_quot;
    presc_t           pset;
    logic [CLK_W-1:0] prod;

    i2c_div_serial #(.W(CLK_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quot (div_quot)
    );

    i2c_div_presc #(.CLK_W(CLK_W)) u_presc (
        .ratio (div_quot),
        .pset  (pset),
        .prod  (prod)
    );

    i2c_div_ctl #(.CLK_W(CLK_W), .RATE_W(RATE_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ref_khz    (ref_khz),
        .bus_khz    (bus_khz),
        .min_khz    (min_khz),
        .max_khz    (max_khz),
        .div_go     (div_go),
        .div_num    (div_num),
        .div_den    (div_den),
        .div_done   (div_done),
        .div_quot   (div_quot),
        .pset       (pset),
        .prod       (prod),
        .done       (done),
        .fit_ok     (fit_ok),
        .no_fit     (no_fit),
        .fine_field (fine_field),
        .sel_coarse (sel_coarse),
        .rate_khz   (rate_khz)
    );

endmodule

// File: tb/i2c_div_search_tb_top.sv
module i2c_div_search_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_W      = 20;
    localparam int RATE_W     = 12;
    localparam int CAND_CYC   = 2 * CLK_W + 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [CLK_W-1:0]  ref_khz;
    logic [RATE_W-1:0] bus_khz;
    logic [RATE_W-1:0] min_khz;
    logic [RATE_W-1:0] max_khz;
    logic              done;
    logic              fit_ok;
    logic              no_fit;
    logic [4:0]        fine_field;
    logic              sel_coarse;
    logic [CLK_W-1:0]  rate_khz;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_div_search #(.CLK_W(CLK_W), .RATE_W(RATE_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .ref_khz(ref_khz),
        .bus_khz(bus_khz), .min_khz(min_khz), .max_khz(max_khz),
        .done(done), .fit_ok(fit_ok), .no_fit(no_fit),
        .fine_field(fine_field), .sel_coarse(sel_coarse), .rate_khz(rate_khz)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Candidate evaluation from R1..R3.
    task automatic ref_eval(input int rclk, input int t,
                            output int sel, output int fine, output int ach);
        int ratio;
        int pre;
        ratio = rclk / t;
        sel   = (ratio > 256) ? 1 : 0;
        pre   = sel ? 512 : 16;
        fine  = (ratio + pre - 1) / pre;
        if (fine < 1) fine = 1;
        if (fine > 17) fine = 17;
        ach   = rclk / (fine * pre);
    endtask

    // Whole search from R4..R7 and latency from R9.
    task automatic ref_search(input int rclk, input int bus, input int mn, input int mx,
                              output int ok, output int fm1, output int sel,
                              output int rate, output int cyc, output int kind);
        int n;
        int scan;
        int t;
        int s;
        int f;
        int a;
        n = 0; scan = 0; ok = 0; fm1 = 0; sel = 0; rate = 0; kind = 7;
        if (bus != 0) begin
            n++;
            ref_eval(rclk, bus, s, f, a);
            if (a - bus <= 2 && bus - a <= 2) begin
                ok = 1; fm1 = f - 1; sel = s; rate = a; kind = 5;
            end
        end
        if (ok == 0) begin
            scan = 1;
            t = (mx != 0) ? mx : bus;
            while (t > mn && ok == 0) begin
                n++;
                ref_eval(rclk, t, s, f, a);
                if (a - t <= 2 && t - a <= 2) begin
                    ok = 1; fm1 = f - 1; sel = s; rate = a; kind = 6;
                end else begin
                    t--;
                end
            end
        end
        cyc = n * CAND_CYC + scan;
    endtask

    task automatic run_case(input int rclk, input int bus, input int mn, input int mx,
                            input bit interfere);
        int ok; int fm1; int sel; int rate; int cyc; int kind;
        int c;
        string tag;
        ref_search(rclk, bus, mn, mx, ok, fm1, sel, rate, cyc, kind);
        tag = (kind == 5) ? "R5" : (kind == 6) ? "R6" : "R7";
        @(negedge clk);
        start   = 1'b1;
        ref_khz = CLK_W'(rclk);
        bus_khz = RATE_W'(bus);
        min_khz = RATE_W'(mn);
        max_khz = RATE_W'(mx);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < 30000) begin
            @(posedge clk);
            c++;
            @(negedge clk);
            if (interfere && c == 3) begin
                start   = 1'b1;          // R8: must be ignored mid-search
                bus_khz = RATE_W'(777);
                ref_khz = CLK_W'(3000);
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk("R9 latency", c, cyc);
        chk({"R4 found flag ", tag}, int'(fit_ok), ok);
        chk({"R7 no-fit flag ", tag}, int'(no_fit), 1 - ok);
        chk("R2 fine field", int'(fine_field), fm1);
        chk("R1 coarse select", int'(sel_coarse), sel);
        chk("R3 achieved rate", int'(rate_khz), rate);
        @(negedge clk);
        chk("R8 done pulse width", int'(done), 0);
    endtask

    int clks [8] = '{1000, 7000, 16000, 33000, 50000, 66000, 100000, 200000};
    int bus_t[9] = '{100, 100, 0,   400, 0, 50, 123, 10, 0};
    int max_t[9] = '{400, 0,   200, 400, 0, 60, 130, 12, 3000};
    int min_t[9] = '{380, 80,  185, 390, 0, 59, 110, 0,  2990};

    initial begin
        rst = 1'b1; start = 1'b0; ref_khz = '0; bus_khz = '0; min_khz = '0; max_khz = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle state after reset
        chk("R10 done", int'(done), 0);
        chk("R10 found", int'(fit_ok), 0);
        chk("R10 no-fit", int'(no_fit), 0);
        chk("R10 fine field", int'(fine_field), 0);
        chk("R10 coarse", int'(sel_coarse), 0);
        chk("R10 rate", int'(rate_khz), 0);

        // Default settings: 100 kHz requested, 400 kHz ceiling (R5 hit at 16 MHz).
        run_case(16000, 100, 0, 400, 1'b0);
        // R8: start pulse with other inputs during a long search is ignored.
        run_case(50000, 100, 380, 400, 1'b1);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 9; j++) begin
                run_case(clks[i], bus_t[j], min_t[j], max_t[j], 1'b0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule